// File: doc/BRIEF.md
# Latched Page-Select Decoder

This block turns the page field of a bus address into one active-high select line per 256-byte page. Each bank holds a small address register and a one-hot decoder. The register is loaded on every rising clock edge while the hold-enable input is high. While hold-enable is low, the register keeps its value, so the outputs go on decoding the stored page even when the address bus moves on.

A global select input, active high as a disable, forces every output low. It wins over the address and over hold-enable. The bank field above the page bits is not registered. It steers the select to exactly one bank: bank 0 is enabled when the bank bit is low, and bank 1 is enabled through an inversion of that bit. With the default sizes, two 16-output banks cover a 13-bit address space as 32 pages.

The block can also act as a demultiplexer. Hold the address steady and drive the data, inverted, on the select input. The chosen page line then carries the data and every other line stays low. For plain address decoding, tie hold-enable high.

Top module: `page_select_decoder`

## Requirements
- R1: A synchronous active-high reset clears the held page address to zero on the next clock edge, and it takes priority over hold-enable. Even during and after reset the outputs still obey the select input and the bank bit, so the page shown is `{bank_bit, 0000}`.
- R2: While hold-enable is high, each rising edge loads address bits 11:8. From that edge on, the output whose index equals the loaded value is high, with bit 11 as the most significant bit.
- R3: While hold-enable is low, the held page value does not change, whatever address bits 11:8 do.
- R4: While the select input is high, all 32 outputs are low, whatever the address, hold-enable or reset.
- R5: While the select input is low, exactly one output is high.
- R6: With the address steady, the selected output equals the inverse of the select input in the same cycle, and all other outputs stay low.
- R7: Address bit 12 is decoded without being held. When it is 0, the active output lies in 0..15; when it is 1, it lies in 16..31. A change of bit 12 takes effect even while hold-enable is low.
- R8: With hold-enable high and select low, every 13-bit address A gives exactly one active output, and its index is A >> 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the held page address |
| hold_en | input | 1 | High: load the page address each edge; low: keep it |
| sel_n | input | 1 | High forces all outputs low; low enables decoding (data input in demultiplexer use) |
| bus_addr_hi | input | 5 | Bus address bits 12:8; bit 12 picks the bank, bits 11:8 the page in the bank |
| page_sel | output | 32 | One-hot active-high page select lines |

## Verification
Two functions can act in the same cycle: the select override and the hold of the page register. The bench changes the select input while hold-enable is low and the address bits are moving. It also switches the bank bit while the held value is frozen. Each result is judged against a bench-side model of the held value. The output must show the frozen page in the bank chosen by the live bit 12, or all zeros when the select is high. The register must not be disturbed, so it must reappear once the select falls.

// File: rtl/pgdec_pkg.sv
package pgdec_pkg;
  localparam int unsigned DEF_BANK_ADDR_W = 4;
  localparam int unsigned DEF_BANK_CNT_W  = 1;
  localparam int unsigned DEF_PAGE_LSB    = 8;
endpackage

// File: rtl/addr_hold_reg.sv
module addr_hold_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/onehot_dec.sv
module onehot_dec #(
  parameter int unsigned IN_W = 4,
  localparam int unsigned OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  code,
  input  logic             kill,
  output logic [OUT_N-1:0] lines
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign lines[i] = !kill && (code == IN_W'(i));
  end
endmodule

// File: rtl/latched_bank.sv
module latched_bank #(
  parameter int unsigned AW = 4,
  localparam int unsigned N = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_en,
  input  logic          disable_i,
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  sel
);
  logic [AW-1:0] held;

  addr_hold_reg #(.W(AW)) u_hold (
    .clk(clk), .rst(rst), .load(hold_en), .d(addr), .q(held)
  );

  onehot_dec #(.IN_W(AW)) u_dec (
    .code(held), .kill(disable_i), .lines(sel)
  );
endmodule

// File: rtl/page_select_decoder.sv
module page_select_decoder
  import pgdec_pkg::*;
#(
  parameter int unsigned BANK_ADDR_W = DEF_BANK_ADDR_W,
  parameter int unsigned BANK_CNT_W  = DEF_BANK_CNT_W,
  parameter int unsigned PAGE_LSB    = DEF_PAGE_LSB,
  localparam int unsigned BUS_W      = PAGE_LSB + BANK_ADDR_W + BANK_CNT_W,
  localparam int unsigned PER_BANK   = 1 << BANK_ADDR_W,
  localparam int unsigned BANKS      = 1 << BANK_CNT_W,
  localparam int unsigned PAGES      = PER_BANK * BANKS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hold_en,
  input  logic                      sel_n,
  input  logic [BUS_W-1:PAGE_LSB]   bus_addr_hi,
  output logic [PAGES-1:0]          page_sel
);
  logic [BANK_ADDR_W-1:0] page_field;
  logic [BANK_CNT_W-1:0]  bank_field;

  assign page_field = bus_addr_hi[PAGE_LSB+BANK_ADDR_W-1:PAGE_LSB];
  assign bank_field = bus_addr_hi[BUS_W-1:PAGE_LSB+BANK_ADDR_W];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic bank_off;
    // bank 0 sees the bank bit directly, bank 1 its inverse
    assign bank_off = sel_n || (bank_field != BANK_CNT_W'(b));

    latched_bank #(.AW(BANK_ADDR_W)) u_bank (
      .clk(clk), .rst(rst), .hold_en(hold_en), .disable_i(bank_off),
      .addr(page_field), .sel(page_sel[b*PER_BANK +: PER_BANK])
    );
  end
endmodule

// File: rtl/page_select_decoder_chk.sv
module page_select_decoder_chk #(
  parameter int unsigned BUS_W    = 13,
  parameter int unsigned PAGE_LSB = 8,
  parameter int unsigned PAGES    = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    hold_en,
  input logic                    sel_n,
  input logic [BUS_W-1:PAGE_LSB] bus_addr_hi,
  input logic [PAGES-1:0]        page_sel
);
  localparam int unsigned HI = BUS_W - 1;
  localparam int unsigned PW = BUS_W - PAGE_LSB;

  // R4
  sel_override_chk: assert property (@(posedge clk) sel_n |-> page_sel == '0);

  // R5
  one_active_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_n |-> $countones(page_sel) == 1);

  // R2
  load_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && $past(hold_en) && !$past(rst)) |->
      page_sel[{bus_addr_hi[HI], $past(bus_addr_hi[HI-1:PAGE_LSB])}]);

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(hold_en) && !$past(rst) && !sel_n && !$past(sel_n) &&
     bus_addr_hi[HI] == $past(bus_addr_hi[HI])) |-> $stable(page_sel));

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !sel_n) |-> page_sel == (PAGES'(1) << {bus_addr_hi[HI], (PW-1)'(0)}));
endmodule

bind page_select_decoder page_select_decoder_chk #(
  .BUS_W(BUS_W), .PAGE_LSB(PAGE_LSB), .PAGES(PAGES)
) u_chk (
  .clk(clk), .rst(rst), .hold_en(hold_en), .sel_n(sel_n),
  .bus_addr_hi(bus_addr_hi), .page_sel(page_sel)
);

// File: tb/page_select_decoder_tb.sv
`timescale 1ns/1ps
module page_select_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hold_en = 1'b1;
  logic        sel_n = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] page_sel;

  int checks = 0;
  int errors = 0;
  logic [3:0] mheld = '0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  page_select_decoder u_dut (
    .clk(clk), .rst(rst), .hold_en(hold_en), .sel_n(sel_n),
    .bus_addr_hi(addr[12:8]), .page_sel(page_sel)
  );

  task automatic drive(input logic r, input logic le, input logic s,
                       input logic [12:0] a, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; hold_en = le; sel_n = s; addr = a;
    if (r)       mheld = '0;
    else if (le) mheld = a[11:8];
    it.exp = s ? 32'd0 : (32'd1 << {a[12], mheld});
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares one item per cycle, just after the edge that applied it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (page_sel !== it.exp) begin
          errors++;
          $display("FAIL %s: page_sel=%h expected=%h", it.tag, page_sel, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset clears held value, select still honoured
    drive(1, 1, 0, 13'h0700, "R1");
    drive(1, 1, 0, 13'h1F00, "R1");
    drive(1, 0, 1, 13'h0300, "R1");
    drive(0, 0, 0, 13'h0A00, "R1");
    // R2 / R5: transparent load of every page in both banks
    for (int i = 0; i < 32; i++) drive(0, 1, 0, 13'(i << 8), "R2");
    // R3: hold with moving address bits 11:8
    drive(0, 1, 0, 13'h0500, "R3");
    for (int i = 0; i < 16; i++) drive(0, 0, 0, 13'((i << 8) | 8'h3C), "R3");
    // R7: bank bit acts while held
    drive(0, 0, 0, 13'h1C00, "R7");
    drive(0, 0, 0, 13'h0200, "R7");
    drive(0, 1, 0, 13'h1E00, "R7");
    // R4: override with load, hold and reset
    drive(0, 1, 1, 13'h1100, "R4");
    drive(0, 0, 1, 13'h0600, "R4");
    drive(0, 0, 0, 13'h0600, "R4");
    drive(1, 1, 1, 13'h0900, "R4");
    // R6: demultiplexer, data on the select input
    drive(0, 1, 0, 13'h0900, "R6");
    drive(0, 1, 1, 13'h0900, "R6");
    drive(0, 1, 1, 13'h0900, "R6");
    drive(0, 1, 0, 13'h0900, "R6");
    drive(0, 0, 1, 13'h1900, "R6");
    drive(0, 0, 0, 13'h1900, "R6");
    // R8: full address sweep
    for (int a = 0; a < 8192; a++) drive(0, 1, 0, 13'(a), "R8");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule